// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory transfer into a stream of single-word transfers. It receives a 16-bit register-select mask, a base byte address and a two-bit addressing mode. For every set mask bit it issues one register number with the word address that register uses. Transfers are offered one per cycle on a valid/ready handshake. The register file and the memory port sit outside the block; it only produces indices and addresses.

Registers always come out in ascending index order, and their addresses always rise in the same order. This holds for all four modes. For the two decrementing modes the block works out, at start, the lowest address the run will touch. It also works out the updated base value that a caller may write back.

When the last transfer has been accepted, a one-cycle done pulse follows and the block is idle again. The cycle that carries the done pulse can also accept the next start.

Top module: `xfer_addr_seq`

## Requirements
- R1: Mask bit i selects register i. Exactly one transfer is issued per set bit, in ascending register order.
- R2: The word size is 4 bytes. Each accepted transfer raises the address of the next transfer by 4, so the lowest selected register gets the lowest address.
- R3: Mode code 0 (increment, step after access): the first address equals the base.
- R4: Mode code 1 (increment, step before access): the first address equals base + 4.
- R5: Mode code 2 (decrement, step after access): the first address equals base − 4n + 4, where n is the number of set mask bits.
- R6: Mode code 3 (decrement, step before access): the first address equals base − 4n.
- R7: The write-back output is base + 4n for mode codes 0 and 1 and base − 4n for codes 2 and 3. It is valid from the cycle after the start is accepted and stays stable until the next accepted start. All address arithmetic wraps modulo 2^AW.
- R8: While a transfer is offered and not accepted, the register number and the address hold steady and valid stays high.
- R9: An accepted start with an all-zero mask issues no transfer. It raises done in the following cycle with a write-back value equal to the base.
- R10: A start pulse while the block is busy is ignored. The running sequence and the write-back value are unchanged.
- R11: Done is high for exactly one cycle, the cycle after the last transfer is accepted, and busy is low in that cycle. A start presented in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a new sequence, taken when idle |
| mask_i | input | 16 | Register-select mask, bit i selects register i |
| base_i | input | 32 | Base byte address |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| busy_o | output | 1 | Sequence in progress |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_ready_i | input | 1 | The consumer accepts the offered transfer |
| xfer_reg_o | output | 4 | Register number of the offered transfer |
| xfer_addr_o | output | 32 | Word address of the offered transfer |
| done_o | output | 1 | One-cycle pulse after the sequence ends |
| wb_addr_o | output | 32 | Updated base value for optional write-back |

## Verification
Two events can land in the same cycle: a new start request, and either the acceptance of the last transfer or the done pulse that follows it. The bench issues every new sequence in the very cycle its predecessor shows done, and checks that the new sequence's first offer appears one cycle later. On some runs it also drives a start with a different mask, base and mode while a transfer is stalled mid-sequence. That stray start must leave the register order, the addresses and the final write-back value exactly as computed for the original request.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    localparam int WORD_SHIFT = 2;
    localparam int WORD_BYTES = 1 << WORD_SHIFT;

    typedef enum logic [1:0] {
        MODE_INC_AFTER  = 2'd0,
        MODE_INC_BEFORE = 2'd1,
        MODE_DEC_AFTER  = 2'd2,
        MODE_DEC_BEFORE = 2'd3
    } xfer_mode_e;

    function automatic logic mode_is_dec(input xfer_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_before(input xfer_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/xfer_seq_plan.sv
module xfer_seq_plan
    import xfer_seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16
) (
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  xfer_mode_e      mode_i,
    output logic [AW-1:0]   first_o,
    output logic [AW-1:0]   final_o
);
    localparam int CW = $clog2(NREG + 1);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [CW-1:0] cnt;
    logic [AW-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CW'(mask_i[i]);
        end
    end

    assign span = AW'(cnt) << WORD_SHIFT;

    always_comb begin
        if (mode_is_dec(mode_i)) begin
            final_o = base_i - span;
            first_o = mode_is_before(mode_i) ? (base_i - span)
                                             : (base_i - span + STEP);
        end else begin
            final_o = base_i + span;
            first_o = mode_is_before(mode_i) ? (base_i + STEP) : base_i;
        end
    end

endmodule

// File: rtl/xfer_seq_pick.sv
module xfer_seq_pick #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask_i,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
    import xfer_seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic [1:0]      mode_i,
    output logic            busy_o,
    output logic            xfer_valid_o,
    input  logic            xfer_ready_i,
    output logic [IW-1:0]   xfer_reg_o,
    output logic [AW-1:0]   xfer_addr_o,
    output logic            done_o,
    output logic [AW-1:0]   wb_addr_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic            busy_q;
    logic            done_q;
    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_q;

    logic [AW-1:0]   plan_first;
    logic [AW-1:0]   plan_final;
    logic [NREG-1:0] rem_next;
    logic            last_xfer;
    logic            accept_start;

    xfer_seq_plan #(.AW(AW), .NREG(NREG)) plan_i (
        .mask_i  (mask_i),
        .base_i  (base_i),
        .mode_i  (xfer_mode_e'(mode_i)),
        .first_o (plan_first),
        .final_o (plan_final)
    );

    xfer_seq_pick #(.NREG(NREG), .IW(IW)) pick_i (
        .mask_i (rem_q),
        .idx_o  (xfer_reg_o)
    );

    assign rem_next     = rem_q & (rem_q - NREG'(1));
    assign last_xfer    = (rem_next == '0);
    assign accept_start = start_i && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rem_q  <= '0;
            addr_q <= '0;
            wb_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_start) begin
                rem_q  <= mask_i;
                addr_q <= plan_first;
                wb_q   <= plan_final;
                if (mask_i == '0) done_q <= 1'b1;
                else              busy_q <= 1'b1;
            end else if (busy_q && xfer_ready_i) begin
                rem_q  <= rem_next;
                addr_q <= addr_q + STEP;
                if (last_xfer) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o       = busy_q;
    assign xfer_valid_o = busy_q;
    assign xfer_addr_o  = addr_q;
    assign done_o       = done_q;
    assign wb_addr_o    = wb_q;

endmodule

// File: rtl/xfer_addr_seq_chk.sv
module xfer_addr_seq_chk #(
    parameter int AW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [NREG-1:0] mask_i,
    input logic            busy_o,
    input logic            xfer_valid_o,
    input logic            xfer_ready_i,
    input logic [IW-1:0]   xfer_reg_o,
    input logic [AW-1:0]   xfer_addr_o,
    input logic            done_o,
    input logic [AW-1:0]   wb_addr_o
);
    AST_REG_RISES: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_reg_o > $past(xfer_reg_o))); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + AW'(4))); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o))); // R8

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && mask_i == '0) |=> (done_o && !xfer_valid_o)); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(wb_addr_o)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R11
endmodule

bind xfer_addr_seq xfer_addr_seq_chk #(.AW(AW), .NREG(NREG)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mask_i       (mask_i),
    .busy_o       (busy_o),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_reg_o   (xfer_reg_o),
    .xfer_addr_o  (xfer_addr_o),
    .done_o       (done_o),
    .wb_addr_o    (wb_addr_o)
);

// File: tb/xfer_addr_seq_tb_top.sv
module xfer_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  mode_i = '0;
    logic        busy_o, xfer_valid_o, done_o;
    logic        xfer_ready_i = 1'b0;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o, wb_addr_o;

    int nchk = 0;
    int nfail = 0;
    int unsigned seed = 32'h1234_5678;
    bit finished = 0;

    always #5 clk = ~clk;

    xfer_addr_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mask_i(mask_i),
        .base_i(base_i), .mode_i(mode_i), .busy_o(busy_o),
        .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
        .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o),
        .done_o(done_o), .wb_addr_o(wb_addr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic run_seq(input logic [15:0] m, input logic [31:0] b,
                           input logic [1:0] md, input bit stall, input bit inject);
        logic [31:0] span, first, wb, exp_addr;
        int n = 0;
        bit injected = 0;
        bit first_x = 1;
        bit stalled = 0;
        string ftag;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        span = 32'(n) * 32'd4;
        case (md)
            2'd0: begin first = b;                 wb = b + span; ftag = "R3 first addr"; end
            2'd1: begin first = b + 32'd4;         wb = b + span; ftag = "R4 first addr"; end
            2'd2: begin first = b - span + 32'd4;  wb = b - span; ftag = "R5 first addr"; end
            default: begin first = b - span;       wb = b - span; ftag = "R6 first addr"; end
        endcase
        // start is driven in the cycle the previous done may be high (R11)
        start_i = 1'b1; mask_i = m; base_i = b; mode_i = md;
        @(negedge clk);
        start_i = 1'b0; mask_i = ~m; base_i = ~b;
        if (m == '0) begin
            chk(done_o && !xfer_valid_o, "R9 empty mask done, no xfer", {30'd0, done_o, xfer_valid_o}, 32'd2);
            chk(wb_addr_o == b, "R9 empty mask write-back", wb_addr_o, b);
            return;
        end
        chk(!done_o && busy_o, "R11 done single cycle, start accepted", {30'd0, done_o, busy_o}, 32'd1);
        exp_addr = first;
        for (int i = 0; i < 16; i++) begin
            if (!m[i]) continue;
            while (1) begin
                chk(xfer_valid_o && xfer_reg_o == 4'(i), stalled ? "R8 held reg" : "R1 reg order",
                    {27'd0, xfer_valid_o, xfer_reg_o}, {27'd1, 4'(i)});
                chk(xfer_addr_o == exp_addr, stalled ? "R8 held addr" : (first_x ? ftag : "R2 addr step"),
                    xfer_addr_o, exp_addr);
                if (stall && next_rand() % 2 == 0) begin
                    stalled = 1;
                    xfer_ready_i = 1'b0;
                    if (inject && !injected) begin
                        start_i = 1'b1; mask_i = ~m; base_i = ~b; mode_i = ~md;
                        injected = 1;
                    end
                    @(negedge clk);
                    start_i = 1'b0; mode_i = md;
                end else break;
            end
            stalled = 0;
            xfer_ready_i = 1'b1;
            @(negedge clk);
            xfer_ready_i = 1'b0;
            first_x = 0;
            exp_addr += 32'd4;
        end
        chk(done_o && !busy_o && !xfer_valid_o, "R11 done after last xfer",
            {29'd0, done_o, busy_o, xfer_valid_o}, 32'd4);
        chk(wb_addr_o == wb, inject ? "R10 write-back after ignored start" : "R7 write-back", wb_addr_o, wb);
    endtask

    initial begin
        logic [31:0] bases [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !xfer_valid_o && !done_o, "reset idle (R11)",
            {29'd0, busy_o, xfer_valid_o, done_o}, 32'd0);
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0000_0008;
        bases[2] = 32'hFFFF_FFF0;
        bases[3] = 32'h8000_0040;
        for (int md = 0; md < 4; md++) begin
            for (int bi = 0; bi < 4; bi++) begin
                run_seq(16'h0000, bases[bi], 2'(md), 0, 0);
                run_seq(16'hFFFF, bases[bi], 2'(md), bi[0], bi[1]);
                for (int k = 0; k < 16; k++)
                    run_seq(16'(1) << k, bases[bi], 2'(md), k[0], 0);
                for (int r = 0; r < 40; r++) begin
                    int unsigned rv = next_rand();
                    run_seq(rv[31:16], {next_rand() & 32'hFFFF_FFFC}, 2'(md), r[0], (r % 5) == 0);
                end
            end
        end
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule